// File: doc/BRIEF.md
# Windowed Indirect SERDES Register Master

This block reaches the control registers inside a multi-lane SERDES PHY that exposes only a small memory-mapped slice at any one time. Each slice access takes two bus transfers. The first writes a page word to a fixed window offset. The second touches the selected slot inside the page. Each PHY register access is then built on top of these pairs. The block programs an indirect address register, a data register and a control register, and it polls a busy flag in the control register.

A client hands over one request: read or write, a 16-bit internal PHY address, a 5-bit device number and, for writes, 16-bit data. The block answers with a one-cycle done pulse. For reads the pulse carries the returned data. An error flag with the pulse reports a busy wait that never ended. Between polls of a busy flag the block leaves the bus idle for a configurable number of cycles. The number of busy answers it accepts before giving up is also configurable.

Top module: `phy_win_master`

## Requirements
- R1: While reset is asserted and after its release, `req_ready` is 1, and `bus_valid` and `req_done` are 0.
- R2: Every transfer to a PHY slot comes directly after a write to bus offset 0x800, with no other transfer between the two. That write carries `(dev << 7) | (addr >> 9)` in bits 11:0. The slot transfer uses bus offset `(addr & 0x1FF) << 2`. Here `addr` is the PHY-internal register being reached.
- R3: A read request performs these steps in order:
  - read the control register 0x80A0 until bit 0 reads 0;
  - write the request address to 0x80A1;
  - write 0x0001 to 0x80A0;
  - read 0x80A0 until bit 0 reads 0;
  - read 0x80A2.
  
  `req_rdata` then equals the value of that last read.
- R4: A write request performs these steps in order, then finishes without polling again:
  - read 0x80A0 until bit 0 reads 0;
  - write the address to 0x80A1;
  - write the data to 0x80A2;
  - write 0x0003 to 0x80A0.
- R5: After a busy answer (bit 0 = 1) the bus stays idle (`bus_valid` = 0) for at least `POLL_GAP` cycles before the next poll starts.
- R6: A single wait that receives `POLL_LIMIT` busy answers ends the request. The block then issues no further transfer and asserts `req_done` together with `req_err`, with `req_rdata` = 0. With `POLL_LIMIT-1` busy answers the request completes normally with `req_err` = 0.
- R7: `req_done` is a one-cycle pulse. `req_ready` is 0 from the accepting edge until the done pulse. Request inputs that change or stay valid during that time have no effect on the sequence in progress.
- R8: Once `bus_valid` is raised, it stays raised until `bus_ready` is seen. `bus_addr`, `bus_write` and `bus_wdata` hold steady during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | PHY device number |
| req_addr | input | 16 | PHY-internal register address |
| req_wdata | input | DW | Write data |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Busy wait exceeded limit (with done) |
| req_rdata | output | DW | Read result (valid with done) |
| bus_valid | output | 1 | Bus transfer requested |
| bus_write | output | 1 | Bus transfer is a write |
| bus_addr | output | 12 | Bus byte offset |
| bus_wdata | output | DW | Bus write data |
| bus_ready | input | 1 | Bus transfer completes this edge |
| bus_rdata | input | DW | Bus read data (valid with bus_ready) |

## Verification
The hardest paths to reach are the repeated busy waits. One is the second wait after the start command. The other is the abort exactly at the poll limit. Both depend on what the PHY answers, not on the request ports. The bench's behavioural responder is therefore preloaded before each request with a count of busy answers for the first wait and another for the wait after start. The sweep covers zero, one and two busy answers per wait. Dedicated runs place the count at one below the limit and at the limit itself. The responder also rebuilds each internal address from the last page word, so any slot access not directly preceded by its page write is caught.

// File: rtl/phy_win_pkg.sv
package phy_win_pkg;

  localparam int PHY_AW = 16;
  localparam int DEV_W  = 5;
  localparam int BUS_AW = 12;

  // page (window) register offset on the bus
  localparam logic [BUS_AW-1:0] WIN_OFF = 12'h800;

  // indirect register triplet inside the PHY address space
  localparam logic [PHY_AW-1:0] IND_CTL  = 16'h80A0;
  localparam logic [PHY_AW-1:0] IND_ADDR = 16'h80A1;
  localparam logic [PHY_AW-1:0] IND_DATA = 16'h80A2;

  localparam int CTL_GO_BIT   = 0;
  localparam int CTL_WR_BIT   = 1;
  localparam int CTL_BUSY_BIT = 0;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_POLL,
    SQ_GAP,
    SQ_SETADDR,
    SQ_SETDATA,
    SQ_KICK,
    SQ_FETCH
  } seq_state_t;

  typedef enum logic [1:0] {
    XF_IDLE,
    XF_WIN,
    XF_ACC
  } xfer_state_t;

  // page word: device in the upper field, top seven address bits below
  function automatic logic [BUS_AW-1:0] win_word(input logic [DEV_W-1:0] dev,
                                                  input logic [PHY_AW-1:0] a);
    return {dev, a[15:9]};
  endfunction

  // slot byte offset inside the page
  function automatic logic [BUS_AW-1:0] slot_off(input logic [PHY_AW-1:0] a);
    return {1'b0, a[8:0], 2'b00};
  endfunction

endpackage

// File: rtl/phy_win_pacer.sv
module phy_win_pacer
  import phy_win_pkg::*;
#(
  parameter int POLL_GAP   = 625,
  parameter int POLL_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gap_load,
  input  logic polls_clr,
  input  logic busy_seen,
  output logic gap_done,
  output logic limit_hit
);

  localparam int GAP_W = (POLL_GAP   > 1) ? $clog2(POLL_GAP + 1)   : 1;
  localparam int LIM_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT + 1) : 1;

  logic [GAP_W-1:0] gap_q, gap_d;
  logic             gap_en;
  logic [LIM_W-1:0] polls_q, polls_d;
  logic             polls_en;

  // gap down-counter
  always_comb begin
    gap_en = gap_load || (gap_q != '0);
    gap_d  = gap_load ? GAP_W'(POLL_GAP - 1) : (gap_q - GAP_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (gap_en) gap_q <= gap_d;
  end

  assign gap_done = (gap_q == '0);

  // busy-answer counter for one wait
  always_comb begin
    polls_en = polls_clr || busy_seen;
    polls_d  = polls_clr ? '0 : (polls_q + LIM_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        polls_q <= '0;
    else if (polls_en) polls_q <= polls_d;
  end

  assign limit_hit = busy_seen && (polls_q == LIM_W'(POLL_LIMIT - 1));

  AST_POLLS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    polls_q < LIM_W'(POLL_LIMIT)); // R6

endmodule

// File: rtl/phy_win_xfer.sv
module phy_win_xfer
  import phy_win_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              wr,
  input  logic [DEV_W-1:0]  dev,
  input  logic [PHY_AW-1:0] reg_addr,
  input  logic [DW-1:0]     wdata,
  output logic              ack,
  output logic [DW-1:0]     rdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [DW-1:0]     bus_wdata,
  input  logic              bus_ready,
  input  logic [DW-1:0]     bus_rdata
);

  xfer_state_t       st_q, st_d;
  logic              cap_en;
  logic              wr_q;
  logic [DEV_W-1:0]  dev_q;
  logic [PHY_AW-1:0] ra_q;
  logic [DW-1:0]     wd_q;

  assign cap_en = (st_q == XF_IDLE) && go;

  always_comb begin
    st_d = st_q;
    case (st_q)
      XF_IDLE: if (go)        st_d = XF_WIN;
      XF_WIN:  if (bus_ready) st_d = XF_ACC;
      XF_ACC:  if (bus_ready) st_d = XF_IDLE;
      default:                st_d = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= XF_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      dev_q <= '0;
      ra_q  <= '0;
      wd_q  <= '0;
    end else if (cap_en) begin
      wr_q  <= wr;
      dev_q <= dev;
      ra_q  <= reg_addr;
      wd_q  <= wdata;
    end
  end

  assign bus_valid = (st_q != XF_IDLE);
  assign bus_write = (st_q == XF_WIN) || ((st_q == XF_ACC) && wr_q);
  assign bus_addr  = (st_q == XF_WIN) ? WIN_OFF : slot_off(ra_q);
  assign bus_wdata = (st_q == XF_WIN) ? DW'(win_word(dev_q, ra_q)) : wd_q;
  assign ack       = (st_q == XF_ACC) && bus_ready;
  assign rdata     = bus_rdata;

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)); // R8

  AST_WIN_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && (bus_addr == WIN_OFF) |-> bus_write); // R2

  AST_SLOT_AFTER_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid && (bus_addr != WIN_OFF)) |-> $past(bus_valid && bus_ready && (bus_addr == WIN_OFF))); // R2

endmodule

// File: rtl/phy_win_master.sv
module phy_win_master
  import phy_win_pkg::*;
#(
  parameter int DW         = 16,
  parameter int POLL_GAP   = 625,
  parameter int POLL_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [4:0]        req_dev,
  input  logic [15:0]       req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_done,
  output logic              req_err,
  output logic [DW-1:0]     req_rdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [11:0]       bus_addr,
  output logic [DW-1:0]     bus_wdata,
  input  logic              bus_ready,
  input  logic [DW-1:0]     bus_rdata
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ln;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end

  assign rst_ln = rsync_q[1];

  seq_state_t        st_q, st_d;
  logic              phase_q, phase_d;
  logic              wr_q;
  logic [DEV_W-1:0]  dev_q;
  logic [PHY_AW-1:0] addr_q;
  logic [DW-1:0]     wd_q;
  logic [DW-1:0]     rdata_q, rdata_d;
  logic              rdata_en;
  logic              done_q, done_d;
  logic              err_q, err_d;

  logic              accept;
  logic              x_go, x_wr, x_ack;
  logic [PHY_AW-1:0] x_reg;
  logic [DW-1:0]     x_wdata, x_rdata;
  logic              busy_seen, gap_load, polls_clr, gap_done, limit_hit;
  logic [DW-1:0]     kick_word;

  assign accept = (st_q == SQ_IDLE) && req_valid;

  always_comb begin
    kick_word             = '0;
    kick_word[CTL_GO_BIT] = 1'b1;
    kick_word[CTL_WR_BIT] = wr_q;
  end

  // per-state transfer selection
  always_comb begin
    x_go    = 1'b0;
    x_wr    = 1'b0;
    x_reg   = IND_CTL;
    x_wdata = '0;
    case (st_q)
      SQ_POLL:    begin x_go = 1'b1; end
      SQ_SETADDR: begin x_go = 1'b1; x_wr = 1'b1; x_reg = IND_ADDR; x_wdata = DW'(addr_q); end
      SQ_SETDATA: begin x_go = 1'b1; x_wr = 1'b1; x_reg = IND_DATA; x_wdata = wd_q; end
      SQ_KICK:    begin x_go = 1'b1; x_wr = 1'b1; x_reg = IND_CTL;  x_wdata = kick_word; end
      SQ_FETCH:   begin x_go = 1'b1; x_reg = IND_DATA; end
      default:    begin x_go = 1'b0; end
    endcase
  end

  assign busy_seen = (st_q == SQ_POLL) && x_ack && x_rdata[CTL_BUSY_BIT];
  assign gap_load  = busy_seen && !limit_hit;
  assign polls_clr = accept || limit_hit || ((st_q == SQ_KICK) && x_ack);

  // sequence next-state
  always_comb begin
    st_d     = st_q;
    phase_d  = phase_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    rdata_en = 1'b0;
    rdata_d  = rdata_q;
    case (st_q)
      SQ_IDLE: begin
        if (req_valid) begin
          st_d    = SQ_POLL;
          phase_d = 1'b0;
        end
      end
      SQ_POLL: begin
        if (x_ack) begin
          if (x_rdata[CTL_BUSY_BIT]) begin
            if (limit_hit) begin
              st_d     = SQ_IDLE;
              done_d   = 1'b1;
              err_d    = 1'b1;
              rdata_en = 1'b1;
              rdata_d  = '0;
            end else begin
              st_d = SQ_GAP;
            end
          end else begin
            st_d = phase_q ? SQ_FETCH : SQ_SETADDR;
          end
        end
      end
      SQ_GAP: begin
        if (gap_done) st_d = SQ_POLL;
      end
      SQ_SETADDR: begin
        if (x_ack) st_d = wr_q ? SQ_SETDATA : SQ_KICK;
      end
      SQ_SETDATA: begin
        if (x_ack) st_d = SQ_KICK;
      end
      SQ_KICK: begin
        if (x_ack) begin
          if (wr_q) begin
            st_d   = SQ_IDLE;
            done_d = 1'b1;
          end else begin
            st_d    = SQ_POLL;
            phase_d = 1'b1;
          end
        end
      end
      SQ_FETCH: begin
        if (x_ack) begin
          st_d     = SQ_IDLE;
          done_d   = 1'b1;
          rdata_en = 1'b1;
          rdata_d  = x_rdata;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      st_q    <= SQ_IDLE;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      phase_q <= phase_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      wr_q   <= 1'b0;
      dev_q  <= '0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (accept) begin
      wr_q   <= req_write;
      dev_q  <= req_dev;
      addr_q <= req_addr;
      wd_q   <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln)       rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  phy_win_xfer #(.DW(DW)) xfer_i (
    .clk       (clk),
    .rst_n     (rst_ln),
    .go        (x_go),
    .wr        (x_wr),
    .dev       (dev_q),
    .reg_addr  (x_reg),
    .wdata     (x_wdata),
    .ack       (x_ack),
    .rdata     (x_rdata),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata)
  );

  phy_win_pacer #(.POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)) pacer_i (
    .clk       (clk),
    .rst_n     (rst_ln),
    .gap_load  (gap_load),
    .polls_clr (polls_clr),
    .busy_seen (busy_seen),
    .gap_done  (gap_done),
    .limit_hit (limit_hit)
  );

  assign req_ready = (st_q == SQ_IDLE);
  assign req_done  = done_q;
  assign req_err   = err_q;
  assign req_rdata = rdata_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_ln)
    req_done |=> !req_done); // R7

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_ln)
    req_err |-> req_done); // R6

  AST_READY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_ln)
    $fell(req_ready) |-> $past(req_valid)); // R7

  AST_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_ln)
    (st_q == SQ_GAP) |-> !bus_valid); // R5

endmodule

// File: tb/phy_win_master_tb.sv
module phy_win_master_tb_top;

  localparam int DW    = 16;
  localparam int GAP   = 3;
  localparam int LIMIT = 5;

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_ready, req_write, req_done, req_err;
  logic [4:0]    req_dev;
  logic [15:0]   req_addr;
  logic [DW-1:0] req_wdata, req_rdata;
  logic          bus_valid, bus_write, bus_ready;
  logic [11:0]   bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  phy_win_master #(.DW(DW), .POLL_GAP(GAP), .POLL_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_done(req_done), .req_err(req_err), .req_rdata(req_rdata),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  // behavioural PHY model state
  logic [15:0] phy_mem [0:65535];
  logic [11:0] cur_win;
  bit          win_fresh;
  logic [15:0] ind_addr, ind_data;
  int          busy_left, busy_after;
  int          win_errs;
  int          cyc;
  int          measuring, idle_run, min_idle;

  // access log
  int          lg_n;
  logic [15:0] lg_ia [0:63];
  bit          lg_wr [0:63];
  logic [15:0] lg_wd [0:63];
  logic [4:0]  lg_dev[0:63];

  // expected log
  int          ex_n;
  logic [15:0] ex_ia [0:63];
  bit          ex_wr [0:63];
  logic [15:0] ex_wd [0:63];

  bit          lat_wr;
  logic [11:0] lat_addr;
  logic [15:0] lat_wd;

  function automatic logic [15:0] slot_ia(input logic [11:0] w, input logic [11:0] off);
    return {w[6:0], off[10:2]};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic rsp_process();
    logic [15:0] ia;
    bit busy_rd;
    if (lat_addr == 12'h800) begin
      if (!lat_wr || win_fresh) win_errs++;
      cur_win   = lat_wd[11:0];
      win_fresh = 1'b1;
      return;
    end
    if (!win_fresh || lat_addr[1:0] != 2'b00 || lat_addr[11]) win_errs++;
    win_fresh = 1'b0;
    ia = slot_ia(cur_win, lat_addr);
    busy_rd = 1'b0;
    if (lat_wr) begin
      if (ia == 16'h80A1) ind_addr = lat_wd;
      else if (ia == 16'h80A2) ind_data = lat_wd;
      else if (ia == 16'h80A0 && lat_wd[0]) begin
        if (lat_wd[1]) phy_mem[ind_addr] = ind_data;
        else           ind_data = phy_mem[ind_addr];
        busy_left = busy_after;
      end
    end else if (ia == 16'h80A0 && busy_left > 0) begin
      busy_left--;
      busy_rd = 1'b1;
    end
    if (lg_n < 64) begin
      lg_ia[lg_n]  = ia;
      lg_wr[lg_n]  = lat_wr;
      lg_wd[lg_n]  = lat_wr ? lat_wd : 16'h0;
      lg_dev[lg_n] = cur_win[11:7];
    end
    lg_n++;
    if (busy_rd) begin
      measuring = 1;
      idle_run  = 0;
    end
  endtask

  // responder: one wait-free cycle per transfer, driven on the falling edge
  initial begin
    bus_ready = 1'b0;
    bus_rdata = '0;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (bus_ready) begin
        bus_ready = 1'b0;
        rsp_process();
      end else if (bus_valid) begin
        lat_wr   = bus_write;
        lat_addr = bus_addr;
        lat_wd   = bus_wdata;
        bus_rdata = '0;
        if (!bus_write && bus_addr != 12'h800) begin
          if (slot_ia(cur_win, bus_addr) == 16'h80A0) bus_rdata = {15'h0, busy_left > 0};
          else if (slot_ia(cur_win, bus_addr) == 16'h80A2) bus_rdata = ind_data;
          else bus_rdata = 16'hDEAD;
        end
        bus_ready = 1'b1;
      end
      if (measuring != 0) begin
        if (bus_valid) begin
          measuring = 0;
          if (idle_run < min_idle) min_idle = idle_run;
        end else idle_run++;
      end
    end
  end

  task automatic ex_add(input logic [15:0] ia, input bit wr, input logic [15:0] wd);
    ex_ia[ex_n] = ia; ex_wr[ex_n] = wr; ex_wd[ex_n] = wr ? wd : 16'h0;
    ex_n++;
  endtask

  task automatic build_exp(input bit wr, input logic [15:0] a, input logic [15:0] wd,
                           input int p, input int q, input bit to_err);
    ex_n = 0;
    for (int i = 0; i < (to_err ? LIMIT : p + 1); i++) ex_add(16'h80A0, 1'b0, 0);
    if (to_err) return;
    ex_add(16'h80A1, 1'b1, a);
    if (wr) ex_add(16'h80A2, 1'b1, wd);
    ex_add(16'h80A0, 1'b1, wr ? 16'h0003 : 16'h0001);
    if (!wr) begin
      for (int i = 0; i < q + 1; i++) ex_add(16'h80A0, 1'b0, 0);
      ex_add(16'h80A2, 1'b0, 0);
    end
  endtask

  task automatic cmp_log(input string rq, input logic [4:0] dev);
    bit ok;
    ok = (lg_n == ex_n);
    for (int i = 0; i < ex_n && ok && i < 64; i++)
      if (lg_ia[i] != ex_ia[i] || lg_wr[i] != ex_wr[i] || lg_wd[i] != ex_wd[i] || lg_dev[i] != dev)
        ok = 1'b0;
    chk(ok, rq, "access sequence (count)", lg_n, ex_n);
  endtask

  // issue one request; p busy answers before, q after the start command
  task automatic do_req(input bit wr, input logic [4:0] dev, input logic [15:0] a,
                        input logic [15:0] wd, input int p, input int q, input bit hold,
                        output logic [15:0] rd, output bit err, output bit seen);
    bit rr;
    int t;
    @(negedge clk);
    lg_n = 0; busy_left = p; busy_after = q;
    req_write = wr; req_dev = dev; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    forever begin
      rr = req_ready;
      @(negedge clk);
      if (rr) break;
    end
    if (hold) begin
      req_addr = a ^ 16'h0F0F; req_write = ~wr; req_dev = dev ^ 5'h3;
    end else req_valid = 1'b0;
    seen = 1'b0;
    t = 0;
    while (!req_done && t < 3000) begin
      if (req_ready) chk(1'b0, "R7", "ready while busy", 1, 0);
      @(negedge clk);
      t++;
    end
    seen = req_done;
    rd = req_rdata; err = req_err;
    req_valid = 1'b0;
    @(negedge clk);
    chk(!req_done, "R7", "done pulse width", req_done, 0);
  endtask

  initial begin
    logic [15:0] rd, wv;
    bit er, sn;
    int devs [3];
    int adrs [6];
    devs = '{0, 9, 31};
    adrs = '{16'h0000, 16'h01FF, 16'h0200, 16'h80A5, 16'hFFFF, 16'h3C4B};
    for (int i = 0; i < 65536; i++) phy_mem[i] = 16'(i * 7 + 16'h1234);
    cur_win = '0; win_fresh = 0; ind_addr = 0; ind_data = 0;
    busy_left = 0; busy_after = 0; win_errs = 0;
    measuring = 0; idle_run = 0; min_idle = 1000000; lg_n = 0;
    req_valid = 0; req_write = 0; req_dev = 0; req_addr = 0; req_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(bus_valid == 0 && req_done == 0 && req_ready == 1, "R1", "state in reset",
        {bus_valid, req_done, req_ready}, 3'b001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(bus_valid == 0 && req_done == 0 && req_ready == 1, "R1", "state after reset",
        {bus_valid, req_done, req_ready}, 3'b001);

    // R2 R3 R4: sweep devices, addresses, busy counts
    foreach (devs[d]) foreach (adrs[k]) for (int p = 0; p < 3; p++) begin
      wv = adrs[k][15:0] ^ {devs[d][4:0], 11'h0} ^ 16'h5A3C ^ 16'(p);
      do_req(1'b1, devs[d][4:0], adrs[k][15:0], wv, p, p, 1'b0, rd, er, sn);
      chk(sn && !er, "R4", "write done/no err", {sn, er}, 2'b10);
      build_exp(1'b1, adrs[k][15:0], wv, p, 0, 1'b0);
      cmp_log("R4/R2", devs[d][4:0]);
      do_req(1'b0, devs[d][4:0], adrs[k][15:0], 16'h0, (p + 1) % 3, p, 1'b0, rd, er, sn);
      chk(sn && !er, "R3", "read done/no err", {sn, er}, 2'b10);
      chk(rd == wv, "R3", "read data", rd, wv);
      build_exp(1'b0, adrs[k][15:0], 0, (p + 1) % 3, p, 1'b0);
      cmp_log("R3/R2", devs[d][4:0]);
    end
    chk(win_errs == 0, "R2", "slot access without fresh page write", win_errs, 0);
    chk(min_idle >= GAP, "R5", "idle cycles after busy answer", min_idle, GAP);

    // R6 boundary: one below the limit succeeds
    do_req(1'b0, 5'd4, 16'h1111, 0, LIMIT - 1, LIMIT - 1, 1'b0, rd, er, sn);
    chk(sn && !er && rd == phy_mem[16'h1111], "R6", "limit-1 busy answers completes", rd, phy_mem[16'h1111]);
    build_exp(1'b0, 16'h1111, 0, LIMIT - 1, LIMIT - 1, 1'b0);
    cmp_log("R6", 5'd4);
    // R6: first wait hits the limit
    do_req(1'b0, 5'd4, 16'h2222, 0, LIMIT, 0, 1'b0, rd, er, sn);
    chk(sn && er, "R6", "error on limit", {sn, er}, 2'b11);
    chk(rd == 0, "R6", "rdata cleared on error", rd, 0);
    build_exp(1'b0, 16'h2222, 0, LIMIT, 0, 1'b1);
    cmp_log("R6", 5'd4);
    // R6: second wait (after start) hits the limit
    do_req(1'b0, 5'd6, 16'h2345, 0, 0, LIMIT, 1'b0, rd, er, sn);
    chk(sn && er, "R6", "error on limit after start", {sn, er}, 2'b11);
    chk(lg_n == 3 + LIMIT, "R6", "transfers before abort", lg_n, 3 + LIMIT);

    // R7: inputs changing while busy are ignored
    do_req(1'b1, 5'd2, 16'h4567, 16'hBEEF, 1, 1, 1'b1, rd, er, sn);
    chk(sn && !er, "R7", "held request done", {sn, er}, 2'b10);
    build_exp(1'b1, 16'h4567, 16'hBEEF, 1, 0, 1'b0);
    cmp_log("R7", 5'd2);
    repeat (4) @(negedge clk);
    chk(bus_valid == 0 && req_ready == 1, "R7", "no second sequence", bus_valid, 0);
    do_req(1'b0, 5'd2, 16'h4567, 0, 0, 0, 1'b0, rd, er, sn);
    chk(rd == 16'hBEEF, "R7", "only original write applied", rd, 16'hBEEF);
    chk(win_errs == 0, "R2", "page discipline end", win_errs, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule